// File: doc/BRIEF.md
# Single-Port RAM LIFO Stack

This block is a last-in first-out stack for a small processor without a pipeline. The whole stack lives in one single-port synchronous RAM. The registered read port of that RAM drives the top-of-stack output directly. There is no separate top register and no bypass path.

The stack pointer always holds the address of the entry that is currently on top. Every push, pop or in-place replace finishes in one clock cycle:

- **Push:** the block moves the pointer up and writes the new word at the new address on the same edge. Because the RAM reads in write-first mode, the word being written also appears on the output after that edge.
- **Pop:** the block moves the pointer down and reads the entry below, so the output shows the older word after the edge.

The depth is a power of two and the word width is a separate parameter. The flags report an empty stack and a full stack. The core clears the pointer with a synchronous reset.

Top module: `lifoRamStack`

## Requirements
- R1: While `rst` is high at a clock edge, the stack becomes empty. After that edge `isEmpty` is 1 and `isFull` is 0, and any `doPush` or `doPop` asserted in that cycle has no effect.
- R2: With `doPush`=1 and `doPop`=0 on a stack that is not full, the value on `pushData` is on `topData` after the edge, and the depth grows by one.
- R3: With `doPop`=1 and `doPush`=0 on a stack that is not empty, the depth drops by one. After the edge `topData` shows the entry pushed just before the removed one, which gives last-in first-out order.
- R4: With `doPush`=1 and `doPop`=1 on a stack that is not empty, the top entry is replaced by `pushData`. The depth stays the same, and after the edge `topData` shows the new value.
- R5: `doPush`=1 with `doPop`=0 on a full stack is ignored. `isFull` stays 1, `topData` keeps its value, and every stored entry is unchanged.
- R6: `doPop`=1 with `doPush`=0 on an empty stack is ignored. `isEmpty` stays 1, and later pushes and pops behave as if the pop never happened.
- R7: `isFull` is 1 exactly when the stack holds DEPTH entries. `isEmpty` is 1 exactly when it holds none. While the stack is empty, `topData` has no defined value.
- R8: `doPush`=1 with `doPop`=1 on an empty stack acts as a plain push, so the stack holds exactly one entry afterwards.
- R9: With neither strobe high, the depth, the flags and `topData` all hold their values across the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every state change happens on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| doPush | input | 1 | Push request |
| doPop | input | 1 | Pop request |
| pushData | input | WIDTH | Word to push, or the replacement word when both strobes are high |
| topData | output | WIDTH | Registered RAM read data holding the current top entry |
| isEmpty | output | 1 | High when the stack holds no entries |
| isFull | output | 1 | High when the stack holds DEPTH entries |

## Verification
The bench goes after the edges of the pointer and the read-during-write case.

- **Wrong read-during-write mode:** a RAM that reads the old word shows stale data one cycle after a push or a replace.
- **Pop reading at the wrong address:** a pop that reads the old top instead of the entry below repeats the removed value.
- **Missing full guard:** a push on a full stack that is not blocked wraps the pointer and overwrites the bottom entry. The bench exposes this by draining the stack afterwards.
- **Missing empty guard:** a pop on an empty stack that is not blocked leaves the pointer underflowed. The next push then lands somewhere the flags cannot explain.
- **Simultaneous push and pop:** this case is driven both on an empty stack and on a full one. It catches a design that moves the pointer when it should replace the top, or that drops the word when it should push.

// File: rtl/lifoStackPkg.sv
package lifoStackPkg;

  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_PUSH = 2'd1,
    OP_POP  = 2'd2,
    OP_SWAP = 2'd3
  } stackOp_e;

  // strobes from control to the RAM datapath
  typedef struct packed {
    logic wrEn;
    logic rdEn;
  } ramStrobe_t;

endpackage

// File: rtl/lifoStackCtl.sv
module lifoStackCtl
  import lifoStackPkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     doPush,
  input  logic                     doPop,
  output ramStrobe_t               strobe,
  output logic [$clog2(DEPTH)-1:0] ramAddr,
  output logic                     isEmpty,
  output logic                     isFull
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = PTR_W + 1;
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [CNT_W-1:0] cntQ;
  logic [CNT_W-1:0] cntD;
  logic [CNT_W-1:0] topIdx;
  logic [CNT_W-1:0] belowIdx;
  stackOp_e         op;

  assign isEmpty  = (cntQ == '0);
  assign isFull   = (cntQ == FULL_CNT);
  assign topIdx   = cntQ - CNT_W'(1);
  assign belowIdx = cntQ - CNT_W'(2);

  // decode requests, dropping those the current depth forbids
  always_comb begin
    op = OP_HOLD;
    if (doPush && doPop) begin
      op = isEmpty ? OP_PUSH : OP_SWAP;
    end else if (doPush && !isFull) begin
      op = OP_PUSH;
    end else if (doPop && !isEmpty) begin
      op = OP_POP;
    end
    if (rst) op = OP_HOLD;
  end

  always_comb begin
    cntD        = cntQ;
    ramAddr     = topIdx[PTR_W-1:0];
    strobe.wrEn = 1'b0;
    strobe.rdEn = !rst;
    unique case (op)
      OP_PUSH: begin
        cntD        = cntQ + CNT_W'(1);
        ramAddr     = cntQ[PTR_W-1:0];
        strobe.wrEn = 1'b1;
      end
      OP_POP: begin
        cntD    = cntQ - CNT_W'(1);
        ramAddr = belowIdx[PTR_W-1:0];
      end
      OP_SWAP: begin
        strobe.wrEn = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) cntQ <= '0;
    else     cntQ <= cntD;
  end

  // R2: accepted push grows the depth by one
  a_r2_push_grows: assert property (@(posedge clk) disable iff (rst)
    (doPush && !doPop && !isFull) |=> (cntQ == $past(cntQ) + CNT_W'(1)));

  // R3: accepted pop shrinks the depth by one
  a_r3_pop_shrinks: assert property (@(posedge clk) disable iff (rst)
    (doPop && !doPush && !isEmpty) |=> (cntQ == $past(cntQ) - CNT_W'(1)));

  // R4: replace keeps the depth
  a_r4_swap_keeps_depth: assert property (@(posedge clk) disable iff (rst)
    (doPush && doPop && !isEmpty) |=> $stable(cntQ));

  // R5: push on full is ignored
  a_r5_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (doPush && !doPop && isFull) |=> (isFull && $stable(cntQ)));

  // R6: pop on empty is ignored
  a_r6_no_underflow: assert property (@(posedge clk) disable iff (rst)
    (doPop && !doPush && isEmpty) |=> (isEmpty && $stable(cntQ)));

  // R7: depth never exceeds capacity
  a_r7_depth_bound: assert property (@(posedge clk) disable iff (rst)
    cntQ <= FULL_CNT);

  // R5: no RAM write while full unless replacing
  a_r5_no_write_full: assert property (@(posedge clk) disable iff (rst)
    (isFull && strobe.wrEn) |-> (doPop && doPush));

endmodule

// File: rtl/lifoStackRam.sv
module lifoStackRam
  import lifoStackPkg::*;
#(
  parameter int DEPTH = 16,
  parameter int WIDTH = 8
) (
  input  logic                     clk,
  input  ramStrobe_t               strobe,
  input  logic [$clog2(DEPTH)-1:0] ramAddr,
  input  logic [WIDTH-1:0]         wrData,
  output logic [WIDTH-1:0]         rdData
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [WIDTH-1:0] rdQ;

  // single port, write-first read during write
  always_ff @(posedge clk) begin
    if (strobe.wrEn) mem[ramAddr] <= wrData;
    if (strobe.rdEn) begin
      if (strobe.wrEn) rdQ <= wrData;
      else             rdQ <= mem[ramAddr];
    end
  end

  assign rdData = rdQ;

endmodule

// File: rtl/lifoRamStack.sv
module lifoRamStack
  import lifoStackPkg::*;
#(
  parameter int DEPTH = 16,
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             doPush,
  input  logic             doPop,
  input  logic [WIDTH-1:0] pushData,
  output logic [WIDTH-1:0] topData,
  output logic             isEmpty,
  output logic             isFull
);
  localparam int PTR_W = $clog2(DEPTH);

  ramStrobe_t       strobe;
  logic [PTR_W-1:0] ramAddr;

  lifoStackCtl #(.DEPTH(DEPTH)) u_ctl (
    .clk     (clk),
    .rst     (rst),
    .doPush  (doPush),
    .doPop   (doPop),
    .strobe  (strobe),
    .ramAddr (ramAddr),
    .isEmpty (isEmpty),
    .isFull  (isFull)
  );

  lifoStackRam #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_ram (
    .clk     (clk),
    .strobe  (strobe),
    .ramAddr (ramAddr),
    .wrData  (pushData),
    .rdData  (topData)
  );

  // R2/R4/R8: an accepted write shows on the output next cycle
  a_r2_write_first: assert property (@(posedge clk) disable iff (rst)
    (doPush && (doPop || !isFull)) |=> (topData == $past(pushData)));

  // R9: idle cycles hold the output
  a_r9_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!doPush && !doPop && !isEmpty) |=> $stable(topData));

  // R1: reset leaves an empty stack
  a_r1_reset_empty: assert property (@(posedge clk)
    rst |=> (isEmpty && !isFull));

endmodule

// File: tb/lifoRamStack_tb.sv
module lifoRamStack_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8;
  localparam int WIDTH = 8;
  localparam int NVEC = 20;

  // {push, pop, data}
  localparam logic [WIDTH+1:0] VEC [NVEC] = '{
    {2'b11, 8'hA5}, {2'b01, 8'h00}, {2'b10, 8'h11}, {2'b10, 8'h22},
    {2'b00, 8'h00}, {2'b10, 8'h33}, {2'b01, 8'h00}, {2'b11, 8'h44},
    {2'b00, 8'hFF}, {2'b01, 8'h00}, {2'b10, 8'h55}, {2'b11, 8'h66},
    {2'b01, 8'h00}, {2'b01, 8'h00}, {2'b01, 8'h00}, {2'b01, 8'h00},
    {2'b11, 8'h77}, {2'b10, 8'h88}, {2'b01, 8'h00}, {2'b01, 8'h00}
  };

  logic             clk = 1'b0;
  logic             rst;
  logic             doPush;
  logic             doPop;
  logic [WIDTH-1:0] pushData;
  logic [WIDTH-1:0] topData;
  logic             isEmpty;
  logic             isFull;

  int total = 0;
  int bad = 0;
  logic [WIDTH-1:0] model [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  lifoRamStack #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_dut (
    .clk(clk), .rst(rst), .doPush(doPush), .doPop(doPop),
    .pushData(pushData), .topData(topData), .isEmpty(isEmpty), .isFull(isFull)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic compareAll(input string tag);
    check({tag, " isEmpty"}, 32'(isEmpty), 32'(model.size() == 0));
    check({tag, " isFull"}, 32'(isFull), 32'(model.size() == DEPTH));
    if (model.size() > 0) check({tag, " topData"}, 32'(topData), 32'(model[$]));
  endtask

  // called at a negedge: drive, update model, check at next negedge
  task automatic step(input logic p, input logic q, input logic [WIDTH-1:0] d);
    string tag;
    doPush = p; doPop = q; pushData = d;
    if (p && q && model.size() > 0) begin
      model[model.size()-1] = d; tag = "R4 replace";
    end else if (p && q) begin
      model.push_back(d); tag = "R8 both-on-empty";
    end else if (p && model.size() < DEPTH) begin
      model.push_back(d); tag = "R2 push";
    end else if (p) begin
      tag = "R5 push-on-full";
    end else if (q && model.size() > 0) begin
      void'(model.pop_back()); tag = "R3 pop";
    end else if (q) begin
      tag = "R6 pop-on-empty";
    end else begin
      tag = "R9 idle";
    end
    @(negedge clk);
    compareAll(tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst = 1'b1; doPush = 1'b0; doPop = 1'b0; pushData = '0;
    @(negedge clk); @(negedge clk);
    check("R1 reset isEmpty", 32'(isEmpty), 32'd1);
    check("R1 reset isFull", 32'(isFull), 32'd0);
    rst = 1'b0;

    for (int i = 0; i < NVEC; i++) begin
      step(VEC[i][WIDTH+1], VEC[i][WIDTH], VEC[i][WIDTH-1:0]);
    end
    while (model.size() > 0) step(1'b0, 1'b1, '0);

    // R6: pops on empty, then normal behaviour
    step(1'b0, 1'b1, '0);
    step(1'b0, 1'b1, '0);
    step(1'b1, 1'b0, 8'h5A);
    step(1'b0, 1'b1, '0);

    // R7 / R5: fill to full, overflow, replace on full, drain
    for (int i = 0; i < DEPTH; i++) begin
      step(1'b1, 1'b0, 8'(8'h10 + i));
      check("R7 full only at capacity", 32'(isFull), 32'(i == DEPTH - 1));
    end
    step(1'b1, 1'b0, 8'hEE);
    step(1'b1, 1'b0, 8'hDD);
    step(1'b1, 1'b1, 8'hC3);
    step(1'b0, 1'b0, '0);
    for (int i = 0; i < DEPTH; i++) step(1'b0, 1'b1, '0);

    // R1: reset mid-stack with push held
    step(1'b1, 1'b0, 8'h01);
    step(1'b1, 1'b0, 8'h02);
    rst = 1'b1; doPush = 1'b1; pushData = 8'h03;
    @(negedge clk);
    model.delete();
    compareAll("R1 reset mid-stack");
    rst = 1'b0;
    step(1'b1, 1'b0, 8'h04);
    step(1'b0, 1'b1, '0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule